// File: doc/BRIEF.md
# Receive Character Buffer with Per-Entry Error Tags

This block buffers characters between a serial receiver and a processor register port. Each stored character carries three tag bits of its own: parity error, framing error and break. The oldest character and its tags are presented continuously on the read side. A one-cycle read strobe drops that character and moves the next one to the head, so the line-status error bits always describe the character the processor is about to take.

Besides the data path, the block reports whether any data is waiting, whether the occupancy has reached a selectable threshold, and whether any stored character still carries a tag. It also keeps a sticky overrun indication, set when the receiver delivers a character into a full buffer. A synchronous clear input empties the buffer at once. Depth is a parameter (2, 4, 8 or 16; default 16).

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, `level` is 0, and `data_ready`, `overrun`, `err_any`, `trig_hit` and `rx_int_req` are all 0.
- R2: Characters and their tags leave in the order they were written. `head_data`, `head_pe`, `head_fe` and `head_bi` show the oldest stored entry whenever `data_ready` is 1.
- R3: Writes are accepted until `DEPTH` entries are held. `level` reports the current occupancy, and `data_ready` is 1 exactly when `level` is nonzero.
- R4: A write while `level` equals `DEPTH` stores nothing, leaves the buffer contents unchanged, and sets `overrun` from the next cycle on.
- R5: `overrun` stays set until a cycle with `status_rd` high clears it. When `status_rd` and an overflowing write occur in the same cycle, `overrun` stays set.
- R6: With `DEPTH`=16, `trig_sel` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 entries. For smaller depths each threshold is scaled by DEPTH/16, with a minimum of 1. `trig_hit` is 1 when `level` is at or above the selected threshold.
- R7: `rx_int_req` is 1 exactly when `trig_hit` and `rx_int_en` are both 1.
- R8: `err_any` is 1 while at least one stored entry has any tag bit set. It falls to 0 in the cycle after the last tagged entry is read out.
- R9: `fifo_clr` empties the buffer and clears `err_any` on the next edge. Writes and reads in that cycle are dropped and do not set `overrun`. `overrun` itself is kept, unless `status_rd` is also high.
- R10: A read on an empty buffer has no effect. A read together with a write on a non-full, non-empty buffer leaves `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Synchronous buffer clear |
| wr_en | input | 1 | Receiver delivers one character |
| wr_data | input | 8 | Received character |
| wr_pe | input | 1 | Parity error tag of the character |
| wr_fe | input | 1 | Framing error tag of the character |
| wr_bi | input | 1 | Break tag of the character |
| rd_en | input | 1 | Processor takes the head character |
| status_rd | input | 1 | Status read; clears overrun |
| trig_sel | input | 2 | Threshold code |
| rx_int_en | input | 1 | Receive interrupt enable |
| head_data | output | 8 | Oldest stored character |
| head_pe | output | 1 | Parity tag of head |
| head_fe | output | 1 | Framing tag of head |
| head_bi | output | 1 | Break tag of head |
| level | output | $clog2(DEPTH+1) | Occupancy |
| data_ready | output | 1 | Buffer not empty |
| trig_hit | output | 1 | Occupancy at or above threshold |
| rx_int_req | output | 1 | Threshold interrupt request |
| err_any | output | 1 | A tagged entry is stored |
| overrun | output | 1 | Sticky overflow flag |

## Verification
Every write, read, clear and status read takes effect at one rising edge. `level`, `data_ready`, `err_any`, `overrun` and the head outputs therefore show the new state right after that edge. `trig_hit` and `rx_int_req` follow from `level` and the static inputs without any further delay. The bench applies one set of inputs per cycle and updates its queue model before the edge. It compares every output half a period after the edge, so each result is checked in the same cycle in which it becomes due.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef struct packed {
        logic       bi;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;

    // Threshold for a code, scaled from a 16-deep reference, floor at one.
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        int base;
        int v;
        case (sel)
            2'd0:    base = 1;
            2'd1:    base = 4;
            2'd2:    base = 8;
            default: base = 14;
        endcase
        v = (base * depth) / 16;
        if (v < 1) v = 1;
        return v;
    endfunction

    function automatic logic has_tag(input rx_entry_t e);
        return e.pe | e.fe | e.bi;
    endfunction

endpackage

// File: rtl/rxf_storage.sv
module rxf_storage
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            push_req,
    input  rx_entry_t       push_entry,
    input  logic            pop_req,
    output rx_entry_t       head,
    output logic [CW-1:0]   count,
    output logic            full,
    output logic            empty,
    output logic            push_done,
    output logic            pop_done
);
    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign push_done = push_req & ~full & ~clr;
    assign pop_done  = pop_req & ~empty & ~clr;
    assign head      = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_done) mem[wp] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_done) wp <= nxt(wp);
            if (pop_done)  rp <= nxt(rp);
            case ({push_done, pop_done})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && !pop_req && !clr) |=> full);
    a_r10_empty_read: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_req && !push_req) |=> empty);
endmodule

// File: rtl/rxf_errtrack.sv
module rxf_errtrack #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic add_err,
    input  logic drop_err,
    output logic err_any
);
    logic [CW-1:0] n_err;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            n_err <= '0;
        end else begin
            case ({add_err, drop_err})
                2'b10:   n_err <= n_err + 1'b1;
                2'b01:   n_err <= n_err - 1'b1;
                default: n_err <= n_err;
            endcase
        end
    end

    assign err_any = (n_err != '0);

    a_r8_err_bound: assert property (@(posedge clk) disable iff (rst)
        n_err <= CW'(DEPTH));
    a_r9_clear_err: assert property (@(posedge clk) disable iff (rst)
        clr |=> !err_any);
endmodule

// File: rtl/rxf_trigger.sv
module rxf_trigger
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [1:0]    sel,
    output logic          hit
);
    logic [CW-1:0] thr;

    always_comb begin
        thr = CW'(trig_level(sel, DEPTH));
        hit = (count >= thr);
    end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_pe,
    input  logic          wr_fe,
    input  logic          wr_bi,
    input  logic          rd_en,
    input  logic          status_rd,
    input  logic [1:0]    trig_sel,
    input  logic          rx_int_en,
    output logic [7:0]    head_data,
    output logic          head_pe,
    output logic          head_fe,
    output logic          head_bi,
    output logic [CW-1:0] level,
    output logic          data_ready,
    output logic          trig_hit,
    output logic          rx_int_req,
    output logic          err_any,
    output logic          overrun
);
    rx_entry_t in_e, head;
    logic full, empty, push_done, pop_done;

    always_comb begin
        in_e.data = wr_data;
        in_e.pe   = wr_pe;
        in_e.fe   = wr_fe;
        in_e.bi   = wr_bi;
    end

    rxf_storage #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(fifo_clr),
        .push_req(wr_en), .push_entry(in_e), .pop_req(rd_en),
        .head(head), .count(level), .full(full), .empty(empty),
        .push_done(push_done), .pop_done(pop_done)
    );

    rxf_errtrack #(.DEPTH(DEPTH)) u_err (
        .clk(clk), .rst(rst), .clr(fifo_clr),
        .add_err(push_done & has_tag(in_e)),
        .drop_err(pop_done & has_tag(head)),
        .err_any(err_any)
    );

    rxf_trigger #(.DEPTH(DEPTH)) u_trig (
        .count(level), .sel(trig_sel), .hit(trig_hit)
    );

    assign head_data  = head.data;
    assign head_pe    = head.pe;
    assign head_fe    = head.fe;
    assign head_bi    = head.bi;
    assign data_ready = ~empty;
    assign rx_int_req = trig_hit & rx_int_en;

    logic ovf_evt;
    assign ovf_evt = wr_en & full & ~fifo_clr;

    always_ff @(posedge clk) begin
        if (rst)            overrun <= 1'b0;
        else if (ovf_evt)   overrun <= 1'b1;
        else if (status_rd) overrun <= 1'b0;
    end

    a_r4_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !fifo_clr) |=> overrun);
    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !status_rd) |=> overrun);
    a_r8_err_needs_data: assert property (@(posedge clk) disable iff (rst)
        err_any |-> data_ready);
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (level == '0));
    a_r6_hit_nonempty: assert property (@(posedge clk) disable iff (rst)
        trig_hit |-> data_ready);
endmodule

// File: tb/rx_err_fifo_tb_top.sv
module rx_err_fifo_tb_top;
    localparam int DEPTH  = 16;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam time PERIOD = 10ns;

    logic clk = 0, rst = 1;
    logic fifo_clr = 0, wr_en = 0, wr_pe = 0, wr_fe = 0, wr_bi = 0;
    logic rd_en = 0, status_rd = 0, rx_int_en = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] trig_sel = 0;
    logic [7:0] head_data;
    logic head_pe, head_fe, head_bi, data_ready, trig_hit, rx_int_req, err_any, overrun;
    logic [CW-1:0] level;

    rx_err_fifo #(.DEPTH(DEPTH)) dut_i (.*);

    always #(PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [10:0] q[$];
    bit m_ov = 0;

    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit any_tag();
        foreach (q[i]) if (q[i][10:8] != 3'b000) return 1;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit hit;
        hit = (q.size() >= thr_of(trig_sel));
        chk("R3 level", int'(level), q.size());
        chk("R3 data_ready", int'(data_ready), int'(q.size() != 0));
        chk("R6 trig_hit", int'(trig_hit), int'(hit));
        chk("R7 rx_int_req", int'(rx_int_req), int'(hit && rx_int_en));
        chk("R8 err_any", int'(err_any), int'(any_tag()));
        chk("R5 overrun", int'(overrun), int'(m_ov));
        if (q.size() != 0)
            chk("R2 head", int'({head_bi, head_fe, head_pe, head_data}), int'(q[0]));
    endtask

    task automatic step(input bit w, input logic [7:0] d, input logic [2:0] tg,
                        input bit r, input bit sr, input bit c,
                        input logic [1:0] sel, input bit ie);
        bit ov_set;
        wr_en = w; wr_data = d; {wr_bi, wr_fe, wr_pe} = tg;
        rd_en = r; status_rd = sr; fifo_clr = c; trig_sel = sel; rx_int_en = ie;
        ov_set = 0;
        if (c) begin
            q.delete();
        end else begin
            ov_set = w && (q.size() == DEPTH);
            if (r && q.size() != 0) void'(q.pop_front());
            if (w && !ov_set) q.push_back({tg, d});
        end
        if (ov_set) m_ov = 1;
        else if (sr) m_ov = 0;
        @(posedge clk);
        #(PERIOD/2);
        check_all();
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1357);
        repeat (3) @(posedge clk);
        rst = 0;
        #(PERIOD/2);
        // R1: reset state
        chk("R1 level", int'(level), 0);
        chk("R1 flags", int'({data_ready, overrun, err_any, trig_hit, rx_int_req}), 0);

        // R10: read of empty buffer
        step(0, 0, 0, 1, 0, 0, 2'd0, 1);
        chk("R10 empty read", int'(level), 0);

        // R3/R6/R7: fill to full sweeping thresholds
        for (int i = 0; i < DEPTH; i++)
            step(1, 8'(i * 7 + 3), (i == 5) ? 3'b010 : 3'b000, 0, 0, 0, 2'(i % 4), 1);
        chk("R3 full level", int'(level), DEPTH);
        for (int s = 0; s < 4; s++) step(0, 0, 0, 0, 0, 0, 2'(s), 1);

        // R4: overflow write dropped, overrun set
        step(1, 8'hEE, 3'b111, 0, 0, 0, 2'd3, 0);
        chk("R4 overrun", int'(overrun), 1);
        chk("R4 level kept", int'(level), DEPTH);

        // R5: overflow with status read keeps overrun; plain status read clears
        step(1, 8'hDD, 3'b000, 0, 1, 0, 2'd3, 0);
        chk("R5 set wins", int'(overrun), 1);
        step(0, 0, 0, 0, 1, 0, 2'd3, 0);
        chk("R5 cleared", int'(overrun), 0);

        // R10: simultaneous read and write on a partly full buffer
        step(0, 0, 0, 1, 0, 0, 2'd0, 0);
        step(1, 8'h55, 3'b000, 1, 0, 0, 2'd0, 0);
        chk("R10 level same", int'(level), DEPTH - 1);

        // R8: read until tagged entry gone
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, 2'd0, 0);
        chk("R8 tag gone", int'(err_any), 0);

        // R9: clear with overrun set keeps overrun
        step(1, 8'h01, 3'b001, 0, 0, 0, 2'd0, 0);
        while (q.size() < DEPTH) step(1, 8'h02, 3'b000, 0, 0, 0, 2'd0, 0);
        step(1, 8'h03, 3'b000, 0, 0, 0, 2'd0, 0);
        step(1, 8'h04, 3'b100, 1, 0, 1, 2'd0, 0);
        chk("R9 cleared level", int'(level), 0);
        chk("R9 overrun kept", int'(overrun), 1);
        chk("R9 err cleared", int'(err_any), 0);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            bit w, r, sr, c;
            logic [2:0] tg;
            w  = ($urandom % 100) < 55;
            r  = ($urandom % 100) < 45;
            sr = ($urandom % 100) < 5;
            c  = ($urandom % 200) == 0;
            tg = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0};
            step(w, 8'($urandom), tg, r, sr, c, 2'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule